// File: doc/BRIEF.md
# Receive Buffer with Fill Trigger and Idle Timeout

This block is the receive byte buffer for one serial channel. The receive shifter writes completed characters into it with a push strobe. The host takes them out with a pop strobe. The oldest stored byte is always visible on the read data port. A control bit selects the buffer mode. In buffered mode, sixteen entries are available. Otherwise the path acts as a single holding register.

Two interrupt requests help the host pace its reads. The data-available request is high while the fill level is at or above a threshold, chosen from four values by a 2-bit select. The timeout request covers data left below that threshold. It rises after four character times pass with no push and no pop while the buffer holds some data but less than the threshold. A character time is marked by a tick input. The timeout request stays up until the host pops a byte.

A push into a full buffer is dropped and raises a sticky overrun flag. A status-read strobe clears this flag. A clear control bit empties the buffer in one cycle.

Top module: `rx_fifo_trig`

## Requirements
- R1: With `fifoEn`=1 the buffer holds up to 16 bytes. `fillCount` reports the stored count. `isEmpty` is high exactly when the count is 0. `isFull` is high exactly when the count equals the capacity.
- R2: With `fifoEn`=0 the capacity is 1 byte, so the path acts as a holding register. Any cycle in which `fifoEn` differs from its value in the previous cycle empties the buffer at that edge. The value before the first cycle after reset is taken as 0.
- R3: Bytes leave in the order they were accepted. `popData` shows the oldest stored byte whenever the buffer is not empty. A pop removes that byte at the clock edge.
- R4: `trigSel` encodes the threshold as 00=1, 01=4, 10=8 and 11=14 bytes when `fifoEn`=1; with `fifoEn`=0 the threshold is 1. `dataAvailIrq` is high exactly while `fillCount` is at or above the threshold.
- R5: A cycle is timeout-eligible when the count is between 1 and the threshold minus 1. Ticks in such cycles advance a window count. A push, a pop, a clear or an ineligible cycle resets the window count to 0. The window count saturates at 4. On the fourth such tick, counted with no push, pop or clear in the same cycle, `timeoutIrq` is set at that edge.
- R6: `timeoutIrq` stays set until a pop or a clear. It is never high while the buffer is empty.
- R7: A push when the buffer is full and no pop happens in the same cycle discards the byte and sets `overrunFlag`. `statusRead` clears the flag, but a new overrun in the same cycle wins. A clear of the buffer does not touch the flag.
- R8: `fifoClr`=1 empties the buffer at the next edge, clears the timeout window count and clears `timeoutIrq`. Push and pop strobes in that cycle are ignored.
- R9: A push and a pop in the same cycle on a non-empty buffer, full included, leave the count unchanged and keep byte order. A pop on an empty buffer is ignored.
- R10: After reset the buffer is empty, and `overrunFlag`, `dataAvailIrq` and `timeoutIrq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | 1 selects the 16-entry buffered mode, 0 the single holding register |
| fifoClr | input | 1 | Empties the buffer and the timeout state |
| trigSel | input | 2 | Data-available threshold select |
| charTick | input | 1 | One pulse per character time |
| pushValid | input | 1 | Write strobe from the receive shifter |
| pushData | input | 8 | Byte to store |
| popStrobe | input | 1 | Host read strobe |
| statusRead | input | 1 | Clears the overrun flag |
| popData | output | 8 | Oldest stored byte |
| fillCount | output | 5 | Number of stored bytes |
| isEmpty | output | 1 | Buffer empty |
| isFull | output | 1 | Buffer at capacity |
| overrunFlag | output | 1 | Sticky overrun indication |
| dataAvailIrq | output | 1 | Fill level at or above the threshold |
| timeoutIrq | output | 1 | Data left unread below the threshold |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `trigSel` and `fifoEn` only change between edges, so the threshold and capacity seen by the buffer are settled for the whole cycle. The stimulus meets this by driving all inputs on the falling edge, including mode and threshold changes in the middle of traffic. The bench compares against a queue-based reference every cycle, with the outputs sampled shortly after each rising edge.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  // Strobes from control to datapath, already qualified against fill state
  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic doFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/rx_fifo_dp.sv
module rx_fifo_dp
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobes.doFlush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.doWrite) wrPtr <= advance(wrPtr);
      if (strobes.doRead)  rdPtr <= advance(rdPtr);
      case ({strobes.doWrite, strobes.doRead})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doWrite && !strobes.doRead) |-> (count < CNT_W'(DEPTH)));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doRead |-> (count != '0));

  // R9
  step_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doFlush |=> ((count == $past(count)) ||
                          (count == $past(count) + CNT_W'(1)) ||
                          (count == $past(count) - CNT_W'(1))));
endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TRIG_LVL0 = 1,
  parameter int TRIG_LVL1 = 4,
  parameter int TRIG_LVL2 = 8,
  parameter int TRIG_LVL3 = 14,
  parameter int TMO_CHARS = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             fifoClr,
  input  logic [1:0]       trigSel,
  input  logic             charTick,
  input  logic             pushValid,
  input  logic             popStrobe,
  input  logic             statusRead,
  input  logic [CNT_W-1:0] count,
  output fifoStrobes_t     strobes,
  output logic             isEmpty,
  output logic             isFull,
  output logic             overrunFlag,
  output logic             dataAvailIrq,
  output logic             timeoutIrq
);
  localparam int TMO_W = $clog2(TMO_CHARS + 1);
  localparam int TRIG_TAB [4] = '{TRIG_LVL0, TRIG_LVL1, TRIG_LVL2, TRIG_LVL3};

  logic             enQ;
  logic             flush, rdOk, wrOk, ovSet;
  logic             eligible, restart, tmoHit;
  logic [CNT_W-1:0] capacity, trigLevel;
  logic [TMO_W-1:0] tmoCnt;

  always_comb begin
    flush     = fifoClr || (fifoEn != enQ);
    capacity  = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
    trigLevel = fifoEn ? CNT_W'(TRIG_TAB[trigSel]) : CNT_W'(1);
    isEmpty   = (count == '0);
    isFull    = (count >= capacity);
    rdOk      = popStrobe && !isEmpty && !flush;
    wrOk      = pushValid && !flush && (!isFull || rdOk);
    ovSet     = pushValid && !flush && !wrOk;
    eligible  = !isEmpty && (count < trigLevel);
    restart   = wrOk || rdOk || flush;
    tmoHit    = eligible && charTick && !restart &&
                (tmoCnt == TMO_W'(TMO_CHARS - 1));
    dataAvailIrq = (count >= trigLevel);
    strobes.doWrite = wrOk;
    strobes.doRead  = rdOk;
    strobes.doFlush = flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ         <= 1'b0;
      tmoCnt      <= '0;
      timeoutIrq  <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      enQ <= fifoEn;

      if (restart || !eligible)
        tmoCnt <= '0;
      else if (charTick && (tmoCnt < TMO_W'(TMO_CHARS)))
        tmoCnt <= tmoCnt + TMO_W'(1);

      if (rdOk || flush)
        timeoutIrq <= 1'b0;
      else if (tmoHit)
        timeoutIrq <= 1'b1;

      if (ovSet)
        overrunFlag <= 1'b1;
      else if (statusRead)
        overrunFlag <= 1'b0;
    end
  end

  // R1
  capacity_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= (enQ ? CNT_W'(DEPTH) : CNT_W'(1)));

  // R6
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> (count != '0));

  // R5
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutIrq) |-> ($past(charTick) && !$past(pushValid)));

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> ($past(pushValid) && $past(isFull)));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (count == '0) && !timeoutIrq);
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 8,
  parameter int TRIG_LVL0 = 1,
  parameter int TRIG_LVL1 = 4,
  parameter int TRIG_LVL2 = 8,
  parameter int TRIG_LVL3 = 14,
  parameter int TMO_CHARS = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              fifoClr,
  input  logic [1:0]        trigSel,
  input  logic              charTick,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popStrobe,
  input  logic              statusRead,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  fillCount,
  output logic              isEmpty,
  output logic              isFull,
  output logic              overrunFlag,
  output logic              dataAvailIrq,
  output logic              timeoutIrq
);
  fifoStrobes_t strobes;

  rx_fifo_ctl #(
    .DEPTH(DEPTH), .TRIG_LVL0(TRIG_LVL0), .TRIG_LVL1(TRIG_LVL1),
    .TRIG_LVL2(TRIG_LVL2), .TRIG_LVL3(TRIG_LVL3),
    .TMO_CHARS(TMO_CHARS), .CNT_W(CNT_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoClr(fifoClr),
    .trigSel(trigSel), .charTick(charTick), .pushValid(pushValid),
    .popStrobe(popStrobe), .statusRead(statusRead), .count(fillCount),
    .strobes(strobes), .isEmpty(isEmpty), .isFull(isFull),
    .overrunFlag(overrunFlag), .dataAvailIrq(dataAvailIrq),
    .timeoutIrq(timeoutIrq)
  );

  rx_fifo_dp #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(pushData),
    .rdData(popData), .count(fillCount)
  );
endmodule

// File: tb/rx_fifo_trig_tb_top.sv
module rx_fifo_trig_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0, fifoClr = 1'b0, charTick = 1'b0;
  logic [1:0] trigSel = 2'b00;
  logic       pushValid = 1'b0, popStrobe = 1'b0, statusRead = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic [7:0] popData;
  logic [4:0] fillCount;
  logic       isEmpty, isFull, overrunFlag, dataAvailIrq, timeoutIrq;

  always #10 clk = ~clk;

  rx_fifo_trig dut_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoClr(fifoClr),
    .trigSel(trigSel), .charTick(charTick), .pushValid(pushValid),
    .pushData(pushData), .popStrobe(popStrobe), .statusRead(statusRead),
    .popData(popData), .fillCount(fillCount), .isEmpty(isEmpty),
    .isFull(isFull), .overrunFlag(overrunFlag),
    .dataAvailIrq(dataAvailIrq), .timeoutIrq(timeoutIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] q[$];
  int  tcnt = 0;
  bit  tirq = 0, ovr = 0, prevEn = 0;
  bit  lastClr = 0, lastBoth = 0;
  int  lvTab [4] = '{1, 4, 8, 14};

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int levelOf();
    return fifoEn ? lvTab[trigSel] : 1;
  endfunction

  task automatic modelStep();
    int  n   = q.size();
    int  cap = fifoEn ? 16 : 1;
    int  lvl = levelOf();
    bit  fl  = fifoClr || (fifoEn != prevEn);
    bit  elig = (n > 0) && (n < lvl);
    lastClr = fl;
    lastBoth = 0;
    if (fl) begin
      q.delete();
      tcnt = 0;
      tirq = 0;
      if (statusRead) ovr = 0;
    end else begin
      bit dPop  = popStrobe && (n > 0);
      bit dPush = pushValid && ((n < cap) || dPop);
      bit rst   = dPop || dPush;
      lastBoth = dPop && dPush;
      if (dPop) tirq = 0;
      else if (elig && charTick && (tcnt == 3) && !rst) tirq = 1;
      if (rst || !elig) tcnt = 0;
      else if (charTick && tcnt < 4) tcnt++;
      if (dPop) void'(q.pop_front());
      if (dPush) q.push_back(pushData);
      if (pushValid && !dPush) ovr = 1;
      else if (statusRead) ovr = 0;
    end
    prevEn = fifoEn;
  endtask

  task automatic compareAll();
    int n = q.size();
    int cap = fifoEn ? 16 : 1;
    string capTag = fifoEn ? "R1" : "R2";
    chk(lastClr ? "R8" : (lastBoth ? "R9" : "R1"), "fillCount", fillCount, n);
    chk("R1", "isEmpty", isEmpty, n == 0);
    chk(capTag, "isFull", isFull, n == cap);
    chk("R4", "dataAvailIrq", dataAvailIrq, n >= levelOf());
    chk("R7", "overrunFlag", overrunFlag, ovr);
    if (n == 0) chk("R6", "timeoutIrq while empty", timeoutIrq, 0);
    else        chk("R5", "timeoutIrq", timeoutIrq, tirq);
    if (n > 0)  chk("R3", "popData", popData, q[0]);
  endtask

  task automatic cyc(bit en, bit clr, logic [1:0] sel, bit tick, bit push,
                     logic [7:0] d, bit pop, bit sread);
    @(negedge clk);
    fifoEn = en; fifoClr = clr; trigSel = sel; charTick = tick;
    pushValid = push; pushData = d; popStrobe = pop; statusRead = sread;
    modelStep();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic idle(bit en, logic [1:0] sel, bit tick, int k);
    for (int i = 0; i < k; i++) cyc(en, 0, sel, tick, 0, 8'h00, 0, 0);
  endtask

  task automatic randPhase(bit en, logic [1:0] sel, int pushPct, int popPct, int k);
    for (int i = 0; i < k; i++)
      cyc(en, ($urandom % 100) < 1, sel, ($urandom % 100) < 30,
          ($urandom % 100) < pushPct, 8'($urandom),
          ($urandom % 100) < popPct, ($urandom % 100) < 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10", "fillCount", fillCount, 0);
    chk("R10", "isEmpty", isEmpty, 1);
    chk("R10", "overrunFlag", overrunFlag, 0);
    chk("R10", "dataAvailIrq", dataAvailIrq, 0);
    chk("R10", "timeoutIrq", timeoutIrq, 0);

    // R1 fill to 16 then R7 overrun
    for (int i = 0; i < 18; i++) cyc(1, 0, 2'b11, 0, 1, 8'(i + 8'h40), 0, 0);
    chk("R1", "full after 16 pushes", fillCount, 16);
    chk("R7", "overrun after extra push", overrunFlag, 1);
    // R9 push+pop when full
    cyc(1, 0, 2'b11, 0, 1, 8'hA5, 1, 0);
    chk("R9", "count kept at full", fillCount, 16);
    cyc(1, 0, 2'b11, 0, 0, 8'h00, 0, 1);
    chk("R7", "overrun cleared by status read", overrunFlag, 0);
    // drain, checking order via compareAll
    for (int i = 0; i < 16; i++) cyc(1, 0, 2'b11, 0, 0, 8'h00, 1, 0);
    cyc(1, 0, 2'b11, 0, 0, 8'h00, 1, 0); // pop on empty ignored (R9)

    // R5 timeout: 3 bytes below threshold 4, then idle ticks
    for (int i = 0; i < 3; i++) cyc(1, 0, 2'b01, 0, 1, 8'(i + 1), 0, 0);
    idle(1, 2'b01, 1, 3);
    chk("R5", "no timeout after three ticks", timeoutIrq, 0);
    idle(1, 2'b01, 1, 1);
    chk("R5", "timeout after fourth tick", timeoutIrq, 1);
    idle(1, 2'b01, 1, 5);
    chk("R6", "timeout held until pop", timeoutIrq, 1);
    cyc(1, 0, 2'b01, 0, 0, 8'h00, 1, 0);
    chk("R6", "timeout cleared by pop", timeoutIrq, 0);
    // push restarts window
    idle(1, 2'b01, 1, 2);
    cyc(1, 0, 2'b01, 1, 1, 8'h77, 0, 0);
    idle(1, 2'b01, 1, 3);
    chk("R5", "push restarted window", timeoutIrq, 0);
    idle(1, 2'b01, 1, 1);
    chk("R5", "timeout after restart", timeoutIrq, 1);
    // R8 clear with push in same cycle
    cyc(1, 1, 2'b01, 1, 1, 8'h99, 0, 0);
    chk("R8", "cleared count", fillCount, 0);
    chk("R8", "cleared timeout", timeoutIrq, 0);

    // R2 holding register mode (mode change flushes)
    cyc(1, 0, 2'b00, 0, 1, 8'h11, 0, 0);
    cyc(0, 0, 2'b00, 0, 1, 8'h22, 0, 0);
    chk("R2", "mode change empties", fillCount, 0);
    cyc(0, 0, 2'b10, 0, 1, 8'h33, 0, 0);
    cyc(0, 0, 2'b10, 0, 1, 8'h44, 0, 0);
    chk("R2", "holding capacity one", fillCount, 1);
    chk("R2", "holding data", popData, 8'h33);
    chk("R7", "holding overrun", overrunFlag, 1);
    cyc(0, 0, 2'b10, 0, 1, 8'h55, 1, 1);
    chk("R9", "holding swap", popData, 8'h55);

    // R4 thresholds per select
    for (int s = 0; s < 4; s++) begin
      cyc(1, 1, 2'(s), 0, 0, 8'h00, 0, 0);
      for (int i = 0; i < 15; i++) cyc(1, 0, 2'(s), 0, 1, 8'(i), 0, 0);
    end

    // random traffic across modes and thresholds
    for (int s = 0; s < 4; s++) begin
      randPhase(1, 2'(s), 60, 40, 800);
      randPhase(1, 2'(s), 30, 30, 800);
      randPhase(1, 2'(s), 20, 60, 400);
    end
    randPhase(0, 2'b01, 50, 40, 600);
    randPhase(1, 2'b10, 50, 50, 600);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule